// File: doc/BRIEF.md
# Dual Channel Command and Update Logic

This block sits behind a serial receiver and turns each committed 16-bit frame into register actions for two converter channels, A and B. Each channel keeps a 12-bit input register (staged value) and a 12-bit DAC register (the value presented to the converter). The upper four bits of a frame select a command and the lower twelve carry data. Depending on the command, data is staged, staged and applied, copied from stage to output, or replaced by a fixed clear value. Two commands change mode flags instead: one turns off chained operation, which the receiver uses, and one selects rising-edge data capture.

An active-low load pin, `ldac_n`, gives hardware control over when staged values reach the outputs. The pin is asynchronous to `clk` and passes through a two-stage synchronizer. A falling edge copies both input registers into the DAC registers. While the synchronized pin stays low, every staging command also applies its data at the moment it is accepted. The load-and-update commands apply their data whatever the pin level.

Frames arrive on a valid/ready stream. `word_ready` is low only while reset is held and is high in every cycle after that. The block therefore never applies back-pressure once it runs, and the sender may present a new frame every cycle.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, `dac_a` and `dac_b` are 0, both input registers are 0, `rise_sel` is 0, `chain_en` is 1, and `word_ready` is 1.
- R2: A frame is taken in a cycle where `word_valid` and `word_ready` are both high. Bits 15:12 of `word_data` are the command and bits 11:0 are the data. The effect is visible on the outputs from the clock edge that accepts the frame.
- R3: Commands 4'b0000 and 4'b1111 change no register, and their data is ignored.
- R4: Command 4'b0001 writes the data to the input and DAC registers of channel A, and 4'b0100 does the same for channel B. This happens regardless of the `ldac_n` level.
- R5: With the synchronized `ldac_n` high, command 4'b0011 writes only the channel A input register and 4'b0110 writes only the channel B input register. The DAC registers keep their values.
- R6: Command 4'b1000 writes the data into both input registers. Command 4'b0111 copies each input register into its DAC register.
- R7: Command 4'b1001 clears `chain_en`, and command 4'b1010 sets `rise_sel`. Each flag then keeps its value until reset.
- R8: Command 4'b1011 sets both input and both DAC registers to 0. Command 4'b1100 sets them all to midscale, 12'h800.
- R9: A falling edge of `ldac_n` copies both input registers into the DAC registers on the third rising clock edge after the pin falls. The copy happens once per edge.
- R10: While the synchronized `ldac_n` is low, commands 4'b0011, 4'b0110 and 4'b1000 also write their data into the matching DAC registers.
- R11: Commands 4'b0010, 4'b0101, 4'b1101 and 4'b1110 change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Frame on `word_data` is valid |
| word_ready | output | 1 | Block accepts a frame this cycle |
| word_data | input | 16 | Command in bits 15:12, data in bits 11:0 |
| ldac_n | input | 1 | Asynchronous active-low load pin |
| dac_a | output | 12 | Channel A DAC register |
| dac_b | output | 12 | Channel B DAC register |
| chain_en | output | 1 | Chained operation enabled flag for the receiver |
| rise_sel | output | 1 | Rising-edge capture select flag |

## Verification
The hardest situation to reach from the ports is automatic update. It needs the synchronized load pin to be low before a staging command is accepted, so the bench holds the pin low for several cycles before sending those frames. The same stimulus also checks that the falling edge on the pin has already copied the staged values exactly once. The bench separates the value staged in an input register from the value shown on the outputs. It does this by pairing staging-only commands with a later copy command or pin edge, and only the copy or edge makes the hidden input registers visible.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  parameter int DW   = 12;
  parameter int CW   = 4;
  parameter int NCH  = 2;
  localparam int FW  = DW + CW;
  localparam logic [DW-1:0] MIDSCALE = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [CW-1:0] {
    OP_NOP0    = 4'b0000,
    OP_LDUP_A  = 4'b0001,
    OP_RB_A    = 4'b0010,
    OP_LDIN_A  = 4'b0011,
    OP_LDUP_B  = 4'b0100,
    OP_RB_B    = 4'b0101,
    OP_LDIN_B  = 4'b0110,
    OP_APPLY   = 4'b0111,
    OP_LDIN_AB = 4'b1000,
    OP_CHN_OFF = 4'b1001,
    OP_RISE    = 4'b1010,
    OP_CLR_Z   = 4'b1011,
    OP_CLR_M   = 4'b1100,
    OP_CTRL    = 4'b1101,
    OP_RSVD    = 4'b1110,
    OP_NOP1    = 4'b1111
  } op_e;

  typedef struct packed {
    logic [NCH-1:0] load;
    logic [NCH-1:0] apply;
    logic           clr;
    logic [DW-1:0]  clr_val;
    logic           chain_off;
    logic           rise_on;
  } act_t;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic low_lvl,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= pin_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign low_lvl = ~s2_q;
  assign fall    = prev_q & ~s2_q;
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
(
  input  logic          fire,
  input  logic [CW-1:0] cmd,
  input  logic          auto_upd,
  output act_t          act
);
  always_comb begin
    act = '0;
    if (fire) begin
      unique case (op_e'(cmd))
        OP_LDUP_A:  begin act.load[0] = 1'b1; act.apply[0] = 1'b1; end
        OP_LDUP_B:  begin act.load[1] = 1'b1; act.apply[1] = 1'b1; end
        OP_LDIN_A:  begin act.load[0] = 1'b1; act.apply[0] = auto_upd; end
        OP_LDIN_B:  begin act.load[1] = 1'b1; act.apply[1] = auto_upd; end
        OP_LDIN_AB: begin act.load = '1; act.apply = {NCH{auto_upd}}; end
        OP_APPLY:   act.apply = '1;
        OP_CHN_OFF: act.chain_off = 1'b1;
        OP_RISE:    act.rise_on = 1'b1;
        OP_CLR_Z:   act.clr = 1'b1;
        OP_CLR_M:   begin act.clr = 1'b1; act.clr_val = MIDSCALE; end
        default:    act = '0;
      endcase
    end
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          apply,
  input  logic          pin_fall,
  input  logic          clr,
  input  logic [DW-1:0] clr_val,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] dac_q
);
  logic [DW-1:0] in_q, in_nxt, dac_nxt;

  always_comb begin
    in_nxt  = clr ? clr_val : (load ? data : in_q);
    dac_nxt = dac_q;
    if (clr)                    dac_nxt = clr_val;
    else if (apply || pin_fall) dac_nxt = in_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q  <= in_nxt;
      dac_q <= dac_nxt;
    end
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_valid,
  output logic          word_ready,
  input  logic [FW-1:0] word_data,
  input  logic          ldac_n,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b,
  output logic          chain_en,
  output logic          rise_sel
);
  logic run_q, fire, ldac_low, ldac_fall;
  act_t act;
  logic [DW-1:0] dac_q [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end
  assign word_ready = run_q & rst_n;
  assign fire       = word_valid & word_ready;

  dac_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ldac_n),
    .low_lvl(ldac_low), .fall(ldac_fall)
  );

  dac_cmd_decode u_dec (
    .fire(fire), .cmd(word_data[FW-1:DW]), .auto_upd(ldac_low), .act(act)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n),
      .load(act.load[c]), .apply(act.apply[c]), .pin_fall(ldac_fall),
      .clr(act.clr), .clr_val(act.clr_val), .data(word_data[DW-1:0]),
      .dac_q(dac_q[c])
    );
  end

  assign dac_a = dac_q[0];
  assign dac_b = dac_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_en <= 1'b1;
      rise_sel <= 1'b0;
    end else begin
      if (act.chain_off) chain_en <= 1'b0;
      if (act.rise_on)   rise_sel <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic        word_ready,
  input logic [15:0] word_data,
  input logic        ldac_low,
  input logic        ldac_fall,
  input logic [11:0] dac_a,
  input logic [11:0] dac_b,
  input logic        chain_en,
  input logic        rise_sel
);
  logic fire;
  assign fire = word_valid && word_ready;

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (word_data[15:12] == 4'h0 || word_data[15:12] == 4'hF) && !ldac_fall
    |=> dac_a == $past(dac_a) && dac_b == $past(dac_b)); // R3
  AST_LDUP_A: assert property (@(posedge clk) disable iff (!rst_n)
    fire && word_data[15:12] == 4'h1 |=> dac_a == $past(word_data[11:0])); // R4
  AST_LDUP_B: assert property (@(posedge clk) disable iff (!rst_n)
    fire && word_data[15:12] == 4'h4 |=> dac_b == $past(word_data[11:0])); // R4
  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && word_data[15:12] == 4'h3 && !ldac_low && !ldac_fall
    |=> dac_a == $past(dac_a)); // R5
  AST_AUTO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && word_data[15:12] == 4'h6 && ldac_low |=> dac_b == $past(word_data[11:0])); // R10
  AST_CLR_MID: assert property (@(posedge clk) disable iff (!rst_n)
    fire && word_data[15:12] == 4'hC |=> dac_a == 12'h800 && dac_b == 12'h800); // R8
  AST_CHAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en |=> !chain_en); // R7
  AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rise_sel |=> rise_sel); // R7
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .ldac_low(ldac_low), .ldac_fall(ldac_fall),
  .dac_a(dac_a), .dac_b(dac_b), .chain_en(chain_en), .rise_sel(rise_sel)
);

// File: tb/dual_dac_ctrl_test.sv
module dual_dac_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [15:0] word_data = '0;
  logic        ldac_n = 1'b1;
  logic [11:0] dac_a, dac_b;
  logic        chain_en, rise_sel;

  int n_chk = 0, n_fail = 0;
  logic [11:0] m_ina = '0, m_inb = '0, m_a = '0, m_b = '0;
  logic        m_chain = 1'b1, m_rise = 1'b0, m_low = 1'b0;
  logic [25:0] exp_q[$];
  string       tag_q[$];
  logic        fired = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dual_dac_ctrl uut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .ldac_n(ldac_n), .dac_a(dac_a), .dac_b(dac_b),
    .chain_en(chain_en), .rise_sel(rise_sel)
  );

  task automatic check(input bit ok, input string tag, input logic [25:0] act, input logic [25:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] outs();
    return {dac_a, dac_b, chain_en, rise_sel};
  endfunction

  // reference model of the command map, written from the requirements
  task automatic send(input logic [3:0] cmd, input logic [11:0] d, input string tag);
    case (cmd)
      4'h1: begin m_ina = d; m_a = d; end
      4'h4: begin m_inb = d; m_b = d; end
      4'h3: begin m_ina = d; if (m_low) m_a = d; end
      4'h6: begin m_inb = d; if (m_low) m_b = d; end
      4'h8: begin m_ina = d; m_inb = d; if (m_low) begin m_a = d; m_b = d; end end
      4'h7: begin m_a = m_ina; m_b = m_inb; end
      4'h9: m_chain = 1'b0;
      4'hA: m_rise = 1'b1;
      4'hB: begin m_ina = '0; m_inb = '0; m_a = '0; m_b = '0; end
      4'hC: begin m_ina = 12'h800; m_inb = 12'h800; m_a = 12'h800; m_b = 12'h800; end
      default: ;
    endcase
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = {cmd, d};
    exp_q.push_back({m_a, m_b, m_chain, m_rise});
    tag_q.push_back(tag);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk);
    ldac_n = v;
    if (!v) begin m_a = m_ina; m_b = m_inb; end
    m_low = !v;
    repeat (4) @(negedge clk);
    check(outs() == {m_a, m_b, m_chain, m_rise}, "R9 pin edge",
          outs(), {m_a, m_b, m_chain, m_rise});
  endtask

  // monitor: note acceptance at the edge, compare at the following falling edge
  always @(posedge clk) fired <= word_valid && word_ready;
  always @(negedge clk) begin
    if (fired && exp_q.size() > 0) begin
      logic [25:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(outs() == e, t, outs(), e);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(word_ready == 1'b0, "R2 ready low in reset", {25'd0, word_ready}, 26'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outs() == {12'h0, 12'h0, 1'b1, 1'b0}, "R1 reset outputs", outs(), {24'h0, 2'b10});
    check(word_ready == 1'b1, "R1 ready after reset", {25'd0, word_ready}, 26'd1);
    send(4'h7, 12'h000, "R1 input regs zero");
    send(4'h3, 12'h123, "R5 stage A only");
    send(4'h6, 12'h456, "R5 stage B only");
    send(4'h7, 12'h000, "R6 apply both");
    send(4'h1, 12'hABC, "R4 load update A");
    send(4'h4, 12'h5A5, "R4 load update B");
    send(4'h0, 12'hFFF, "R3 nop 0000");
    send(4'hF, 12'h111, "R3 nop 1111");
    send(4'h2, 12'h222, "R11 readback A");
    send(4'h5, 12'h333, "R11 readback B");
    send(4'hD, 12'h444, "R11 control word");
    send(4'hE, 12'h555, "R11 reserved");
    send(4'h8, 12'h321, "R6 stage both");
    drive_pin(1'b0);
    send(4'h3, 12'h777, "R10 auto A");
    send(4'h6, 12'h0F0, "R10 auto B");
    send(4'h8, 12'h9E1, "R10 auto both");
    send(4'hC, 12'h000, "R8 midscale");
    drive_pin(1'b1);
    send(4'h1, 12'h042, "R4 update with pin high");
    send(4'hB, 12'hFFF, "R8 clear zero");
    send(4'h7, 12'h000, "R8 inputs cleared");
    send(4'hA, 12'h000, "R7 rise select");
    send(4'h9, 12'h000, "R7 chain off");
    send(4'h0, 12'h000, "R7 flags held");
    send(4'h3, 12'h0AA, "R2 back to back a");
    send(4'h6, 12'h0BB, "R2 back to back b");
    drive_pin(1'b0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all frames seen", 26'(exp_q.size()), 26'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule